// File: doc/BRIEF.md
# Starvation Lock Arbitration Table

This block tracks, for a single cache line, every requestor that has gone into starvation mode and broadcast a persistent request. Each requestor owns one slot. A persistent read or persistent write message activates the sender's slot and records its access type. A release message clears that slot. From the active slots the block derives several results:

- whether the line is locked;
- which requestor currently wins, by fixed lowest-ID priority, and whether that winner wants write access;
- how many requestors are starving in total, and how many of them want read access.

Every coherence node holds an identical copy of this table. Because of that, all nodes agree on the winner without any extra messages.

After each accepted message the block also tells the local node how to react. It classifies the change as an unlock, a lockdown by another node, or an own lock. An own lock is further split by whether the local node held tokens in the message cycle. The local node also has a mark input, which it pulses when it issues its own persistent request. The mark snapshots the set of active slots. The node may not issue a new persistent request until every snapshotted requestor has released, which keeps one node from starving the others.

Top module: `starve_arbiter`

## Requirements
- R1: A message with valid high and kind 2'b01 (persistent read) activates slot `msg_src` with read type; kind 2'b10 (persistent write) activates it with write type; a later lock from the same source replaces its type.
- R2: Kind 2'b11 (release) deactivates slot `msg_src`; releasing a slot that is not active changes nothing.
- R3: `locked` is high exactly when at least one slot is active, and it reflects a message from the cycle after that message.
- R4: `winner_id` is the lowest-numbered active slot and `winner_write` is its type (1 = write); both are 0 when nothing is active.
- R5: `starve_cnt` counts active slots and `read_cnt` counts active read-type slots.
- R6: One cycle after each message of kind 2'b01, 2'b10 or 2'b11, `evt_valid` pulses and `evt_code` is computed from the updated table: 2'b00 unlock (no active slot), 2'b01 lockdown (the winner is not `self_id`), 2'b10 own lock with `self_has_tokens` low in the message cycle, 2'b11 own lock with it high.
- R7: A message of kind 2'b00, or any cycle with `msg_valid` low, changes no slot and produces no event.
- R8: When `mark_en` is high, the set of slots that are active after that cycle's message is recorded. `may_issue` stays low while any recorded slot is still active. A slot released in the same cycle as the mark is not recorded.
- R9: After reset no slot is active or recorded: `locked`, the counts and `evt_valid` are 0, and `may_issue` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_valid | input | 1 | A persistent message is presented this cycle |
| msg_kind | input | 2 | 00 none, 01 persistent read, 10 persistent write, 11 release |
| msg_src | input | ID_W | Requestor that sent the message |
| self_id | input | ID_W | ID of the local node |
| self_has_tokens | input | 1 | Local node holds at least one token for the line |
| mark_en | input | 1 | Local node issues its own persistent request; snapshot active slots |
| locked | output | 1 | At least one slot is active |
| winner_id | output | ID_W | Lowest active requestor |
| winner_write | output | 1 | Winner requests write access |
| starve_cnt | output | CNT_W | Number of active slots |
| read_cnt | output | CNT_W | Number of active read-type slots |
| may_issue | output | 1 | No snapshotted slot remains active |
| evt_valid | output | 1 | Local lock event is valid this cycle |
| evt_code | output | 2 | Local lock event code |

## Verification
The mark snapshot and a table update can land in the same clock. The cases that matter most are a mark together with a lock from another requestor, and a mark together with the release of a slot that is about to be recorded. The bench drives these coincidences on purpose in its directed steps, and it also drives them often with random stimulus in which marks fall on message cycles. The behavioural model decides the result by applying the message first and then snapshotting the resulting set. It then compares `may_issue`, together with every other output, on every clock.

// File: rtl/starve_arb_pkg.sv
package starve_arb_pkg;
  typedef enum logic [1:0] {
    KIND_NONE    = 2'b00,
    KIND_READ    = 2'b01,
    KIND_WRITE   = 2'b10,
    KIND_RELEASE = 2'b11
  } msg_kind_e;

  typedef enum logic [1:0] {
    EVT_UNLOCK   = 2'b00,
    EVT_LOCKDOWN = 2'b01,
    EVT_OWN_DRY  = 2'b10,
    EVT_OWN_TOK  = 2'b11
  } lock_evt_e;
endpackage

// File: rtl/starve_arb_store.sv
module starve_arb_store
  import starve_arb_pkg::*;
#(
  parameter int NUM_REQ = 8,
  parameter int ID_W    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               msg_valid,
  input  msg_kind_e          msg_kind,
  input  logic [ID_W-1:0]    msg_src,
  input  logic               mark_en,
  output logic [NUM_REQ-1:0] act_q,
  output logic [NUM_REQ-1:0] wr_q,
  output logic [NUM_REQ-1:0] mark_q,
  output logic [NUM_REQ-1:0] act_d,
  output logic [NUM_REQ-1:0] wr_d
);

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_slot
    logic hit;
    logic en;
    logic a_n, w_n, m_n;
    logic a_r, w_r, m_r;

    always_comb begin
      hit = msg_valid && (msg_src == ID_W'(g));
      a_n = a_r;
      w_n = w_r;
      if (hit) begin
        case (msg_kind)
          KIND_READ:    begin a_n = 1'b1; w_n = 1'b0; end
          KIND_WRITE:   begin a_n = 1'b1; w_n = 1'b1; end
          KIND_RELEASE: begin a_n = 1'b0; w_n = 1'b0; end
          default:      begin a_n = a_r;  w_n = w_r;  end
        endcase
      end
      m_n = mark_en ? a_n : (m_r & a_n);
      en  = (hit && (msg_kind != KIND_NONE)) || mark_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_r <= 1'b0;
        w_r <= 1'b0;
        m_r <= 1'b0;
      end else if (en) begin
        a_r <= a_n;
        w_r <= w_n;
        m_r <= m_n;
      end
    end

    assign act_q[g]  = a_r;
    assign wr_q[g]   = w_r;
    assign mark_q[g] = m_r;
    assign act_d[g]  = a_n;
    assign wr_d[g]   = w_n;
  end

endmodule

// File: rtl/starve_arb_prio.sv
module starve_arb_prio #(
  parameter int NUM_REQ = 8,
  parameter int ID_W    = 3
) (
  input  logic [NUM_REQ-1:0] vec,
  input  logic [NUM_REQ-1:0] wtype,
  output logic               any,
  output logic [ID_W-1:0]    idx,
  output logic               wr
);

  // Scan from the top down so the lowest active index is the last written.
  always_comb begin
    any = 1'b0;
    idx = '0;
    wr  = 1'b0;
    for (int i = NUM_REQ - 1; i >= 0; i--) begin
      if (vec[i]) begin
        any = 1'b1;
        idx = ID_W'(i);
        wr  = wtype[i];
      end
    end
  end

endmodule

// File: rtl/starve_arb_popcnt.sv
module starve_arb_popcnt #(
  parameter int NUM_REQ = 8,
  parameter int CNT_W   = 4
) (
  input  logic [NUM_REQ-1:0] vec,
  output logic [CNT_W-1:0]   cnt
);

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      cnt = cnt + CNT_W'(vec[i]);
    end
  end

endmodule

// File: rtl/starve_arb_event.sv
module starve_arb_event
  import starve_arb_pkg::*;
#(
  parameter int ID_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  logic            lock_d,
  input  logic [ID_W-1:0] win_d,
  input  logic [ID_W-1:0] self_id,
  input  logic            self_has_tokens,
  output logic            evt_valid,
  output lock_evt_e       evt_code
);

  lock_evt_e code_d;
  lock_evt_e code_q;
  logic      vld_q;

  always_comb begin
    if (!lock_d) begin
      code_d = EVT_UNLOCK;
    end else if (win_d != self_id) begin
      code_d = EVT_LOCKDOWN;
    end else if (self_has_tokens) begin
      code_d = EVT_OWN_TOK;
    end else begin
      code_d = EVT_OWN_DRY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= fire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= EVT_UNLOCK;
    end else if (fire) begin
      code_q <= code_d;
    end
  end

  assign evt_valid = vld_q;
  assign evt_code  = code_q;

endmodule

// File: rtl/starve_arbiter.sv
module starve_arbiter
  import starve_arb_pkg::*;
#(
  parameter int NUM_REQ = 8,
  localparam int ID_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
  localparam int CNT_W  = $clog2(NUM_REQ + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_valid,
  input  logic [1:0]       msg_kind,
  input  logic [ID_W-1:0]  msg_src,
  input  logic [ID_W-1:0]  self_id,
  input  logic             self_has_tokens,
  input  logic             mark_en,
  output logic             locked,
  output logic [ID_W-1:0]  winner_id,
  output logic             winner_write,
  output logic [CNT_W-1:0] starve_cnt,
  output logic [CNT_W-1:0] read_cnt,
  output logic             may_issue,
  output logic             evt_valid,
  output logic [1:0]       evt_code
);

  msg_kind_e          kind;
  logic [NUM_REQ-1:0] act_q, wr_q, mark_q, act_d, wr_d;
  logic               lock_d;
  logic [ID_W-1:0]    win_d;
  logic               win_wr_d;
  logic               fire;
  lock_evt_e          evt_e;

  assign kind = msg_kind_e'(msg_kind);
  assign fire = msg_valid && (kind != KIND_NONE);

  starve_arb_store #(.NUM_REQ(NUM_REQ), .ID_W(ID_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .msg_valid(msg_valid),
    .msg_kind (kind),
    .msg_src  (msg_src),
    .mark_en  (mark_en),
    .act_q    (act_q),
    .wr_q     (wr_q),
    .mark_q   (mark_q),
    .act_d    (act_d),
    .wr_d     (wr_d)
  );

  // Arbitration over the registered table drives the visible winner.
  starve_arb_prio #(.NUM_REQ(NUM_REQ), .ID_W(ID_W)) u_prio_now (
    .vec  (act_q),
    .wtype(wr_q),
    .any  (locked),
    .idx  (winner_id),
    .wr   (winner_write)
  );

  // Arbitration over the next table drives the local lock event.
  starve_arb_prio #(.NUM_REQ(NUM_REQ), .ID_W(ID_W)) u_prio_next (
    .vec  (act_d),
    .wtype(wr_d),
    .any  (lock_d),
    .idx  (win_d),
    .wr   (win_wr_d)
  );

  starve_arb_popcnt #(.NUM_REQ(NUM_REQ), .CNT_W(CNT_W)) u_cnt_all (
    .vec(act_q),
    .cnt(starve_cnt)
  );

  starve_arb_popcnt #(.NUM_REQ(NUM_REQ), .CNT_W(CNT_W)) u_cnt_rd (
    .vec(act_q & ~wr_q),
    .cnt(read_cnt)
  );

  starve_arb_event #(.ID_W(ID_W)) u_evt (
    .clk            (clk),
    .rst_n          (rst_n),
    .fire           (fire),
    .lock_d         (lock_d),
    .win_d          (win_d),
    .self_id        (self_id),
    .self_has_tokens(self_has_tokens),
    .evt_valid      (evt_valid),
    .evt_code       (evt_e)
  );

  assign evt_code  = evt_e;
  assign may_issue = ~|mark_q;

  logic unused_win_wr;
  assign unused_win_wr = win_wr_d;

endmodule

// File: rtl/starve_arbiter_chk.sv
module starve_arbiter_chk #(
  parameter int NUM_REQ = 8,
  localparam int ID_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
  localparam int CNT_W  = $clog2(NUM_REQ + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msg_valid,
  input logic [1:0]       msg_kind,
  input logic [ID_W-1:0]  msg_src,
  input logic [ID_W-1:0]  self_id,
  input logic             self_has_tokens,
  input logic             mark_en,
  input logic             locked,
  input logic [ID_W-1:0]  winner_id,
  input logic             winner_write,
  input logic [CNT_W-1:0] starve_cnt,
  input logic [CNT_W-1:0] read_cnt,
  input logic             may_issue,
  input logic             evt_valid,
  input logic [1:0]       evt_code
);

  assert_write_top_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_kind == 2'b10 && msg_src == '0) |=> (winner_id == '0 && winner_write));

  assert_release_shrinks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_kind == 2'b11) |=> (starve_cnt <= $past(starve_cnt)));

  assert_lock_vs_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    locked == (starve_cnt != '0));

  assert_idle_winner_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (winner_id == '0 && !winner_write));

  assert_read_within_total_R5: assert property (@(posedge clk) disable iff (!rst_n)
    read_cnt <= starve_cnt);

  assert_own_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_code[1]) |-> (locked && winner_id == self_id));

  assert_unlock_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_code == 2'b00) |-> !locked);

  assert_no_event_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!msg_valid || msg_kind == 2'b00) |=> !evt_valid);

  assert_mark_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_en && !msg_valid && locked) |=> !may_issue);

endmodule

bind starve_arbiter starve_arbiter_chk #(.NUM_REQ(NUM_REQ)) u_chk (.*);

// File: tb/sim_starve_arbiter.sv
`timescale 1ns/1ps
module sim_starve_arbiter;
  localparam int N  = 8;
  localparam int IW = 3;
  localparam int CW = 4;

  logic          clk;
  logic          rst_n;
  logic          msg_valid;
  logic [1:0]    msg_kind;
  logic [IW-1:0] msg_src;
  logic [IW-1:0] self_id;
  logic          self_has_tokens;
  logic          mark_en;
  logic          locked;
  logic [IW-1:0] winner_id;
  logic          winner_write;
  logic [CW-1:0] starve_cnt;
  logic [CW-1:0] read_cnt;
  logic          may_issue;
  logic          evt_valid;
  logic [1:0]    evt_code;

  starve_arbiter #(.NUM_REQ(N)) u0 (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  bit m_act[N];
  bit m_wr[N];
  bit m_mk[N];
  bit m_ev_v;
  int m_ev_c;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin m_act[i] = 0; m_wr[i] = 0; m_mk[i] = 0; end
      m_ev_v = 0;
      m_ev_c = 0;
    end else begin
      bit fire;
      int w;
      fire = msg_valid && (msg_kind != 2'b00);
      if (fire) begin
        if (msg_kind == 2'b11) begin
          m_act[msg_src] = 0; m_wr[msg_src] = 0;
        end else begin
          m_act[msg_src] = 1; m_wr[msg_src] = (msg_kind == 2'b10);
        end
      end
      for (int i = 0; i < N; i++) m_mk[i] = mark_en ? m_act[i] : (m_mk[i] && m_act[i]);
      m_ev_v = fire;
      if (fire) begin
        w = -1;
        for (int i = N - 1; i >= 0; i--) if (m_act[i]) w = i;
        if (w < 0) m_ev_c = 0;
        else if (w != int'(self_id)) m_ev_c = 1;
        else m_ev_c = self_has_tokens ? 3 : 2;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int w, c, r;
      bit ww, busy;
      w = 0; ww = 0; c = 0; r = 0; busy = 0;
      for (int i = N - 1; i >= 0; i--) if (m_act[i]) begin w = i; ww = m_wr[i]; end
      for (int i = 0; i < N; i++) begin
        c += m_act[i];
        r += (m_act[i] && !m_wr[i]);
        busy |= m_mk[i];
      end
      check(locked == (c != 0), "R3 locked", locked, c != 0);
      check(winner_id == w, "R4 winner_id", winner_id, w);
      check(winner_write == ww, "R4 winner_write", winner_write, ww);
      check(starve_cnt == c, "R5 starve_cnt", starve_cnt, c);
      check(read_cnt == r, "R5 read_cnt", read_cnt, r);
      check(may_issue == !busy, "R8 may_issue", may_issue, !busy);
      check(evt_valid == m_ev_v, "R6/R7 evt_valid", evt_valid, m_ev_v);
      if (m_ev_v) check(evt_code == m_ev_c, "R6 evt_code", evt_code, m_ev_c);
    end
  end

  task automatic cyc(input bit v, input logic [1:0] k, input int s, input bit m, input bit t);
    @(negedge clk);
    msg_valid = v; msg_kind = k; msg_src = IW'(s); mark_en = m; self_has_tokens = t;
  endtask

  task automatic idle();
    cyc(0, 2'b00, 0, 0, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++; tests++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; msg_valid = 0; msg_kind = 0; msg_src = 0; mark_en = 0;
    self_has_tokens = 0; self_id = 3'd3;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!locked && starve_cnt == 0 && read_cnt == 0, "R9 reset table", starve_cnt, 0);
    check(may_issue && !evt_valid, "R9 reset flags", {may_issue, evt_valid}, 2);

    cyc(1, 2'b01, 5, 0, 0); idle();
    check(winner_id == 5 && !winner_write, "R1 read lock", winner_id, 5);
    check(evt_valid && evt_code == 2'b01, "R6 lockdown", evt_code, 1);
    cyc(1, 2'b10, 5, 0, 0); idle();
    check(winner_write && read_cnt == 0, "R1 type replaced", winner_write, 1);
    cyc(1, 2'b01, 3, 0, 1); idle();
    check(winner_id == 3 && evt_code == 2'b11, "R6 own lock with tokens", evt_code, 3);
    cyc(1, 2'b10, 1, 0, 0); idle();
    check(winner_id == 1 && evt_code == 2'b01, "R4 lower id wins", winner_id, 1);
    cyc(1, 2'b11, 6, 0, 0); idle();
    check(starve_cnt == 3, "R2 release of inactive slot", starve_cnt, 3);
    cyc(1, 2'b00, 1, 0, 0); idle();
    check(!evt_valid && starve_cnt == 3 && winner_id == 1, "R7 kind none ignored", evt_valid, 0);
    cyc(1, 2'b01, 0, 1, 0); idle();
    check(!may_issue && winner_id == 0, "R8 mark with lock", may_issue, 0);
    check(starve_cnt == 4 && read_cnt == 2, "R5 counts", read_cnt, 2);
    cyc(1, 2'b11, 0, 0, 0); cyc(1, 2'b11, 1, 0, 0); cyc(1, 2'b11, 5, 0, 0); idle();
    check(!may_issue && starve_cnt == 1, "R8 one marked slot left", may_issue, 0);
    check(evt_code == 2'b10, "R6 own lock without tokens", evt_code, 2);
    cyc(1, 2'b11, 3, 0, 0); idle();
    check(may_issue && !locked, "R8 all marked released", may_issue, 1);
    check(evt_valid && evt_code == 2'b00, "R6 unlock", evt_code, 0);
    cyc(1, 2'b10, 2, 0, 0); cyc(1, 2'b11, 2, 1, 0); idle();
    check(may_issue && !locked, "R8 mark with same-cycle release", may_issue, 1);
    check(starve_cnt == 0, "R2 release clears", starve_cnt, 0);

    for (int n = 0; n < 600; n++) begin
      cyc(($urandom % 10) != 0, 2'($urandom), int'($urandom % N),
          ($urandom % 12) == 0, 1'($urandom));
    end
    idle(); idle();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule